// File: doc/BRIEF.md
# Memory-Mapped Serial Character Port

This block is a bus slave that gives a processor a byte-wide serial channel through four 32-bit registers. Each direction has a status register and a data register. Writing the transmit data register passes one byte to a downstream character sink over a valid/ready handshake. A byte strobed in by an upstream character source is held until the processor reads it from the receive data register.

Each direction drives its own level interrupt line. A line is high when that direction's ready flag and its enable flag are both set. The registers sit in a 16-byte window whose base is a parameter. Read data is combinational in the cycle of the access. A parameter can add a register stage on the interrupt outputs. Bit serialization, baud timing and queuing are handled outside this block.

Top module: `serport_regs`

## Requirements
- R1: An access is decoded only when `bus_addr` bits above bit 3 match the base address. Address bits [3:2] select the register: 0 receive status, 1 receive data, 2 transmit status, 3 transmit data. Bits [1:0] are ignored. An access outside the window changes nothing and reads 0.
- R2: In both status registers, bit 0 is the ready flag and bit 1 is the interrupt enable. In the receive status register, bit 2 is the overrun flag. All other bits read 0. A status write changes only bit 1.
- R3: After reset, both enables, receive ready and overrun are 0, transmit ready is 1, and `tx_valid` is 0.
- R4: A write to transmit data while transmit ready is 1 loads bits [7:0] of the written word into `tx_byte`. From the next cycle, transmit ready is 0 and `tx_valid` is 1.
- R5: A cycle with `tx_valid` and `tx_ready` both high sets transmit ready back to 1 on the following cycle.
- R6: A write to transmit data while transmit ready is 0 is ignored: `tx_byte` and the flags stay unchanged.
- R7: An `rx_stb` cycle stores `rx_byte` and sets receive ready from the next cycle. A read of receive data returns the byte in bits [7:0] with the upper bits zero, and clears receive ready after that cycle.
- R8: A strobe while receive ready is 1 overwrites the held byte and sets the sticky overrun flag. The exception is a strobe in the same cycle as a receive data read, which does not set overrun. A read of receive status clears overrun unless a new overrun occurs in that cycle.
- R9: `irq_tx` equals transmit ready AND transmit enable. `irq_rx` equals receive ready AND receive enable. With the default `IRQ_REG` of 0, both follow the flags in the same cycle.
- R10: `bus_rdata` shows the addressed register in the same cycle as a read request (`bus_req` high, `bus_we` low), and is 0 when no read is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| tx_valid | output | 1 | Byte offered to the sink |
| tx_byte | output | CHAR_W | Byte offered to the sink |
| tx_ready | input | 1 | Sink takes the byte this cycle |
| rx_stb | input | 1 | Source delivers a byte this cycle |
| rx_byte | input | CHAR_W | Byte from the source |
| irq_tx | output | 1 | Transmit-ready interrupt request |
| irq_rx | output | 1 | Receive-ready interrupt request |

## Verification
Read data is due in the same cycle as the request, so the bench drives each access after the falling edge and samples `bus_rdata` shortly afterwards, before the rising edge. Every flag change caused by a write, a strobe, a sink accept or a read side effect becomes visible one rising edge later. The bench therefore updates its model only after the sampling point, and compares `tx_valid`, `tx_byte` and both interrupt lines against the model in the next cycle. With the default setting the interrupts are compared in the same cycle as the flags that drive them.

// File: rtl/serport_pkg.sv
package serport_pkg;

   typedef enum logic [1:0] {
      REG_RX_STAT = 2'd0,
      REG_RX_DATA = 2'd1,
      REG_TX_STAT = 2'd2,
      REG_TX_DATA = 2'd3
   } serport_reg_e;

   localparam int RDY_BIT   = 0;
   localparam int IE_BIT    = 1;
   localparam int OVR_BIT   = 2;
   localparam int WIN_LSB   = 4;
   localparam int SEL_LSB   = 2;

endpackage

// File: rtl/serport_tx.sv
module serport_tx #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CHAR_W-1:0] load_byte,
   input  logic              ie_we,
   input  logic              ie_d,
   input  logic              sink_ready,
   output logic              rdy,
   output logic              ie,
   output logic              valid,
   output logic [CHAR_W-1:0] byte_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy    <= 1'b1;
         ie     <= 1'b0;
         byte_q <= '0;
      end else begin
         if (ie_we) ie <= ie_d;
         if (load && rdy) begin
            rdy    <= 1'b0;
            byte_q <= load_byte;
         end else if (!rdy && sink_ready) begin
            rdy <= 1'b1;
         end
      end
   end

   assign valid = !rdy;

   a_r4_busy_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      (load && rdy) |=> (!rdy && valid));

   a_r5_ready_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && sink_ready) |=> rdy);

   a_r6_byte_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !rdy |=> $stable(byte_q));

endmodule

// File: rtl/serport_rx.sv
module serport_rx #(
   parameter int CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic [CHAR_W-1:0] stb_byte,
   input  logic              take,
   input  logic              stat_rd,
   input  logic              ie_we,
   input  logic              ie_d,
   output logic              rdy,
   output logic              ie,
   output logic              ovr,
   output logic [CHAR_W-1:0] byte_q
);

   logic lost;
   assign lost = stb && rdy && !take;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy    <= 1'b0;
         ie     <= 1'b0;
         ovr    <= 1'b0;
         byte_q <= '0;
      end else begin
         if (ie_we) ie <= ie_d;
         if (stb) begin
            rdy    <= 1'b1;
            byte_q <= stb_byte;
         end else if (take) begin
            rdy <= 1'b0;
         end
         if (lost)         ovr <= 1'b1;
         else if (stat_rd) ovr <= 1'b0;
      end
   end

   a_r7_ready_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      stb |=> (rdy && byte_q == $past(stb_byte)));

   a_r7_clear_on_take: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !stb) |=> !rdy);

   a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !stat_rd) |=> ovr);

   a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && rdy && !take) |=> ovr);

endmodule

// File: rtl/serport_regs.sv
module serport_regs
   import serport_pkg::*;
#(
   parameter int               ADDR_W    = 32,
   parameter int               DATA_W    = 32,
   parameter int               CHAR_W    = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_C000,
   parameter bit               IRQ_REG   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              tx_valid,
   output logic [CHAR_W-1:0] tx_byte,
   input  logic              tx_ready,
   input  logic              rx_stb,
   input  logic [CHAR_W-1:0] rx_byte,
   output logic              irq_tx,
   output logic              irq_rx
);

   localparam int PAD_W = DATA_W - CHAR_W;

   if (CHAR_W > DATA_W || DATA_W < 3) begin : g_bad_width
      $error("serport_regs: DATA_W must hold CHAR_W and three status bits");
   end
   if (ADDR_W <= WIN_LSB) begin : g_bad_addr
      $error("serport_regs: ADDR_W too small for the register window");
   end
   if (BASE_ADDR[WIN_LSB-1:0] != '0) begin : g_bad_base
      $error("serport_regs: BASE_ADDR must be aligned to the 16-byte window");
   end

   logic         hit, rd, wr;
   serport_reg_e sel;

   assign hit = (bus_addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB]);
   assign sel = serport_reg_e'(bus_addr[WIN_LSB-1:SEL_LSB]);
   assign rd  = bus_req && !bus_we && hit;
   assign wr  = bus_req &&  bus_we && hit;

   logic unused_bits;
   assign unused_bits = ^{bus_addr[SEL_LSB-1:0], bus_wdata};

   logic              tx_rdy, tx_ie;
   logic              rx_rdy, rx_ie, rx_ovr;
   logic [CHAR_W-1:0] rx_held;

   serport_tx #(.CHAR_W(CHAR_W)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (wr && sel == REG_TX_DATA),
      .load_byte  (bus_wdata[CHAR_W-1:0]),
      .ie_we      (wr && sel == REG_TX_STAT),
      .ie_d       (bus_wdata[IE_BIT]),
      .sink_ready (tx_ready),
      .rdy        (tx_rdy),
      .ie         (tx_ie),
      .valid      (tx_valid),
      .byte_q     (tx_byte)
   );

   serport_rx #(.CHAR_W(CHAR_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .stb      (rx_stb),
      .stb_byte (rx_byte),
      .take     (rd && sel == REG_RX_DATA),
      .stat_rd  (rd && sel == REG_RX_STAT),
      .ie_we    (wr && sel == REG_RX_STAT),
      .ie_d     (bus_wdata[IE_BIT]),
      .rdy      (rx_rdy),
      .ie       (rx_ie),
      .ovr      (rx_ovr),
      .byte_q   (rx_held)
   );

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         unique case (sel)
            REG_RX_STAT: begin
               bus_rdata[RDY_BIT] = rx_rdy;
               bus_rdata[IE_BIT]  = rx_ie;
               bus_rdata[OVR_BIT] = rx_ovr;
            end
            REG_RX_DATA: bus_rdata = {{PAD_W{1'b0}}, rx_held};
            REG_TX_STAT: begin
               bus_rdata[RDY_BIT] = tx_rdy;
               bus_rdata[IE_BIT]  = tx_ie;
            end
            default:     bus_rdata = '0;
         endcase
      end
   end

   if (IRQ_REG) begin : g_irq_flop
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            irq_tx <= 1'b0;
            irq_rx <= 1'b0;
         end else begin
            irq_tx <= tx_rdy && tx_ie;
            irq_rx <= rx_rdy && rx_ie;
         end
      end
   end else begin : g_irq_comb
      assign irq_tx = tx_rdy && tx_ie;
      assign irq_rx = rx_rdy && rx_ie;
   end

   a_r1_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !hit) |-> (bus_rdata == '0));

   a_r2_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && sel == REG_TX_STAT) |-> (bus_rdata[DATA_W-1:IE_BIT+1] == '0));

   a_r6_busy_write_no_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> tx_valid);

endmodule

// File: tb/tb_serport_regs.sv
module tb_serport_regs;

   localparam int          CLK_T = 10;
   localparam logic [31:0] BASE  = 32'hFFFF_C000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        bus_req, bus_we;
   logic [31:0] bus_addr, bus_wdata, bus_rdata;
   logic        tx_valid, tx_ready;
   logic [7:0]  tx_byte;
   logic        rx_stb;
   logic [7:0]  rx_byte;
   logic        irq_tx, irq_rx;

   serport_regs dut (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
      .rx_stb(rx_stb), .rx_byte(rx_byte), .irq_tx(irq_tx), .irq_rx(irq_rx)
   );

   always #(CLK_T/2) clk = ~clk;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   // bench model of the register state
   bit       m_txr, m_txie, m_rxr, m_rxie, m_ovr;
   bit [7:0] m_txb, m_rxb;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic bit in_win(input logic [31:0] a);
      return a[31:4] == BASE[31:4];
   endfunction

   function automatic logic [31:0] exp_read(input bit req, input bit we,
                                            input logic [31:0] a);
      if (!req || we || !in_win(a)) return 32'h0;
      case (a[3:2])
         2'd0:    return {29'h0, m_ovr, m_rxie, m_rxr};
         2'd1:    return {24'h0, m_rxb};
         2'd2:    return {30'h0, m_txie, m_txr};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string rd_tag(input logic [31:0] a);
      if (!in_win(a)) return "R1";
      case (a[3:2])
         2'd1:    return "R7";
         2'd3:    return "R1";
         default: return "R2";
      endcase
   endfunction

   // one bus cycle: drive after falling edge, check before rising edge, update model
   task automatic step(input bit req, input bit we, input logic [31:0] a,
                       input logic [31:0] wd, input bit stb, input logic [7:0] sb,
                       input bit sink, input string tag);
      bit hit, rdd, wrd;
      @(negedge clk);
      bus_req = req; bus_we = we; bus_addr = a; bus_wdata = wd;
      rx_stb = stb; rx_byte = sb; tx_ready = sink;
      #1;
      chk(tag == "" ? rd_tag(a) : tag, "rdata", bus_rdata, exp_read(req, we, a));
      chk(tag == "" ? "R4" : tag, "tx_valid", {31'h0, tx_valid}, {31'h0, !m_txr});
      chk(tag == "" ? "R4" : tag, "tx_byte", {24'h0, tx_byte}, {24'h0, m_txb});
      chk(tag == "" ? "R9" : tag, "irq_tx", {31'h0, irq_tx}, {31'h0, m_txr & m_txie});
      chk(tag == "" ? "R9" : tag, "irq_rx", {31'h0, irq_rx}, {31'h0, m_rxr & m_rxie});
      hit = in_win(a);
      rdd = req && !we && hit;
      wrd = req && we && hit;
      if (wrd && a[3:2] == 2'd3 && m_txr) begin
         m_txr = 1'b0; m_txb = wd[7:0];
      end else if (!m_txr && sink) begin
         m_txr = 1'b1;
      end
      if (wrd && a[3:2] == 2'd2) m_txie = wd[1];
      if (wrd && a[3:2] == 2'd0) m_rxie = wd[1];
      if (stb && m_rxr && !(rdd && a[3:2] == 2'd1)) m_ovr = 1'b1;
      else if (rdd && a[3:2] == 2'd0)               m_ovr = 1'b0;
      if (stb) begin
         m_rxr = 1'b1; m_rxb = sb;
      end else if (rdd && a[3:2] == 2'd1) begin
         m_rxr = 1'b0;
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(CLK_T * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; bus_req = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
      rx_stb = 0; rx_byte = 0; tx_ready = 0;
      m_txr = 1; m_txie = 0; m_rxr = 0; m_rxie = 0; m_ovr = 0; m_txb = 0; m_rxb = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R3 reset state
      step(0, 0, BASE, 0, 0, 0, 0, "R3");
      step(1, 0, BASE + 32'h0, 0, 0, 0, 0, "R3");
      step(1, 0, BASE + 32'h8, 0, 0, 0, 0, "R3");
      // R1 out-of-window write ignored, then state seen through window
      step(1, 1, BASE + 32'h1C, 32'hEE, 0, 0, 0, "R1");
      step(1, 0, BASE + 32'h18, 0, 0, 0, 0, "R1");
      step(1, 0, BASE + 32'h8, 0, 0, 0, 0, "R1");
      // R2 only bit 1 writable
      step(1, 1, BASE + 32'h8, 32'hFFFF_FFFF, 0, 0, 0, "R2");
      step(1, 0, BASE + 32'hA, 0, 0, 0, 0, "R2");
      // R4 load, R6 busy write, R5 accept
      step(1, 1, BASE + 32'hC, 32'h1234_56A5, 0, 0, 0, "R4");
      step(0, 0, BASE, 0, 0, 0, 0, "R4");
      step(1, 1, BASE + 32'hC, 32'h0000_005A, 0, 0, 0, "R6");
      step(1, 0, BASE + 32'h8, 0, 0, 0, 0, "R6");
      step(0, 0, BASE, 0, 0, 0, 1, "R5");
      step(1, 0, BASE + 32'h8, 0, 0, 0, 0, "R5");
      // R7 receive path, R10 same-cycle read
      step(1, 1, BASE + 32'h0, 32'h0000_0002, 0, 0, 0, "R2");
      step(0, 0, BASE, 0, 1, 8'h3C, 0, "R7");
      step(1, 0, BASE + 32'h4, 0, 0, 0, 0, "R10");
      step(1, 0, BASE + 32'h0, 0, 0, 0, 0, "R7");
      // R8 overrun and its clear
      step(0, 0, BASE, 0, 1, 8'h11, 0, "R8");
      step(0, 0, BASE, 0, 1, 8'h22, 0, "R8");
      step(1, 0, BASE + 32'h0, 0, 0, 0, 0, "R8");
      step(1, 0, BASE + 32'h0, 0, 0, 0, 0, "R8");
      step(1, 0, BASE + 32'h4, 0, 0, 0, 0, "R8");
      // R8 strobe coinciding with data read: no overrun
      step(0, 0, BASE, 0, 1, 8'h33, 0, "R8");
      step(1, 0, BASE + 32'h4, 0, 1, 8'h44, 0, "R8");
      step(1, 0, BASE + 32'h0, 0, 0, 0, 0, "R8");

      // constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] a;
         bit          rq, we;
         a  = BASE + {28'h0, 2'($urandom_range(0, 3)), 2'($urandom_range(0, 3))};
         if ($urandom_range(0, 15) == 0) a = $urandom();
         rq = ($urandom_range(0, 2) != 0);
         we = $urandom_range(0, 1);
         step(rq, we, a, $urandom(), ($urandom_range(0, 3) == 0),
              8'($urandom()), ($urandom_range(0, 2) == 0), "");
      end
      summary();
   end

endmodule